// File: doc/BRIEF.md
# BCD Calendar Clock Core

The block keeps wall-clock time (seconds, minutes, hours in 24-hour form, weekday, day of month, month and two-digit year) as packed BCD bytes. It also holds three alarm compare bytes that software may load. A single byte-wide address/data register port reads and writes all of them, along with a read-only status byte and a one-bit control register. A prescaler divides the core clock down to one-second steps. On each step the time advances with full carry through month lengths and a leap year every fourth year.

Each second ends with an update window. An update-in-progress flag in the status byte rises a fixed number of ticks before the registers change. A reader that polls the status byte and finds the flag clear therefore has a guaranteed interval in which its reads are coherent. During the last part of that window, the busy phase, the core is unbuffered: every time, date and alarm read returns FFh, and writes to those registers are dropped. Setting the hold bit freezes the prescaler so software can load a new time. While the hold bit is set the flag stays low.

The prescaler length, the warning lead and the busy length are parameters. Their defaults are 64, 8 and 4 ticks, so a second passes in 64 cycles.

Top module: `bcd_calendar_clock`

## Requirements
- R1: After reset the register port reads 00h for seconds, minutes, hours and all three alarms, 01h for weekday, day of month and month, 00h for year, 26h for status and 00h for control.
- R2: The register map uses these addresses: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 weekday, 7 day of month, 8 month, 9 year, 10 status, 11 control (bit 0 is the hold bit). Outside the busy phase, a write to addresses 0–9 or 11 reads back as written. Addresses 12–15 always read 00h and ignore writes.
- R3: Counting ticks from 0 at the start of a second (or at hold release), status bit 7 is 1 for ticks TICKS_PER_SEC−WARN_TICKS−BUSY_TICKS through TICKS_PER_SEC−1 and 0 otherwise. The status byte therefore reads A6h while the flag is set and 26h while it is clear.
- R4: During ticks TICKS_PER_SEC−BUSY_TICKS through TICKS_PER_SEC−1, reads of addresses 0–9 return FFh.
- R5: Time registers change only once per TICKS_PER_SEC ticks. The new values are visible from tick 0 of the following second, when the flag is clear again.
- R6: Seconds and minutes wrap 59→00 and carry. Hours wrap 23→00 and carry into the date. Weekday counts 1..7 and wraps 7→1 on each day carry.
- R7: Day of month wraps to 01 after day 30 in months 04, 06, 09 and 11, after day 31 in the other long months, and after day 28 in month 02, or day 29 when the year value is divisible by 4 (year 00 included).
- R8: Month wraps 12→01 with a carry into the year, and the year wraps 99→00.
- R9: While the hold bit is set, no time register advances, the flag reads 0, and the tick count restarts at 0 on release.
- R10: Writes to addresses 0–9 during the busy phase have no effect.
- R11: Alarm bytes change only by writes and are never touched by the once-per-second update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; one tick of the prescaler per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_we | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |

## Verification
Every cycle, the assertions check the following: FFh blanking during the busy phase, that the status byte takes only its two codes with bit 7 equal to the internal flag, that the flag always leads the busy phase, that the hold bit silences the flag and the step, and that seconds and alarm bytes stay steady except on a write or a step. Only the bench's scenarios can show the calendar arithmetic: the carry chain from seconds to year, month lengths, leap years and the exact tick on which the flag, blanking and the new second appear. The bench checks these against its own integer model across directed rollovers and randomly chosen dates.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

  localparam int N_ALARM = 3;

  // register map
  localparam logic [3:0] A_SEC      = 4'd0;
  localparam logic [3:0] A_MIN      = 4'd2;
  localparam logic [3:0] A_HOUR     = 4'd4;
  localparam logic [3:0] A_DOW      = 4'd6;
  localparam logic [3:0] A_DOM      = 4'd7;
  localparam logic [3:0] A_MON      = 4'd8;
  localparam logic [3:0] A_YEAR     = 4'd9;
  localparam logic [3:0] A_STAT     = 4'd10;
  localparam logic [3:0] A_CTRL     = 4'd11;

  localparam logic [6:0] STAT_LOW   = 7'h26;
  localparam logic [7:0] BLANK_BYTE = 8'hFF;

  typedef struct packed {
    logic [7:0] year;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hour;
    logic [7:0] min;
    logic [7:0] sec;
  } cal_now_t;

  localparam cal_now_t NOW_RESET = '{year: 8'h00, mon: 8'h01, dom: 8'h01,
                                     dow: 8'h01, hour: 8'h00, min: 8'h00,
                                     sec: 8'h00};

  // add one to a packed BCD byte
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // last valid day (BCD) of a BCD month; leap when BCD year divisible by 4
  function automatic logic [7:0] last_day(input logic [7:0] mon, input logic [7:0] year);
    logic leap;
    leap = year[4] ? (year[1:0] == 2'b10) : (year[1:0] == 2'b00);
    case (mon)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/cal_sec_timer.sv
module cal_sec_timer #(
  parameter int TICKS_PER_SEC = 64,
  parameter int WARN_TICKS    = 8,
  parameter int BUSY_TICKS    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic uip,
  output logic busy,
  output logic step
);
  localparam int CW = $clog2(TICKS_PER_SEC);
  localparam logic [CW-1:0] LAST_TICK = CW'(TICKS_PER_SEC - 1);
  localparam logic [CW-1:0] WARN_AT   = CW'(TICKS_PER_SEC - WARN_TICKS - BUSY_TICKS);
  localparam logic [CW-1:0] BUSY_AT   = CW'(TICKS_PER_SEC - BUSY_TICKS);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (hold)                    cnt_d = '0;
    else if (cnt_q == LAST_TICK) cnt_d = '0;
    else                         cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign uip  = !hold && (cnt_q >= WARN_AT);
  assign busy = !hold && (cnt_q >= BUSY_AT);
  assign step = !hold && (cnt_q == LAST_TICK);

endmodule

// File: rtl/cal_time_keeper.sv
module cal_time_keeper
  import cal_clock_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  input  logic                        wr_en,
  input  logic [3:0]                  addr,
  input  logic [7:0]                  wr_data,
  output cal_now_t                    now_q,
  output logic [N_ALARM-1:0][7:0]     alarm_q
);
  cal_now_t now_d;
  logic     now_en;

  always_comb begin
    now_d = now_q;
    if (wr_en) begin
      case (addr)
        A_SEC:   now_d.sec  = wr_data;
        A_MIN:   now_d.min  = wr_data;
        A_HOUR:  now_d.hour = wr_data;
        A_DOW:   now_d.dow  = wr_data;
        A_DOM:   now_d.dom  = wr_data;
        A_MON:   now_d.mon  = wr_data;
        A_YEAR:  now_d.year = wr_data;
        default: ;
      endcase
    end else if (step) begin
      if (now_q.sec != 8'h59) begin
        now_d.sec = bcd_inc(now_q.sec);
      end else begin
        now_d.sec = 8'h00;
        if (now_q.min != 8'h59) begin
          now_d.min = bcd_inc(now_q.min);
        end else begin
          now_d.min = 8'h00;
          if (now_q.hour < 8'h23) begin
            now_d.hour = bcd_inc(now_q.hour);
          end else begin
            now_d.hour = 8'h00;
            now_d.dow  = (now_q.dow >= 8'h07) ? 8'h01 : bcd_inc(now_q.dow);
            if (now_q.dom < last_day(now_q.mon, now_q.year)) begin
              now_d.dom = bcd_inc(now_q.dom);
            end else begin
              now_d.dom = 8'h01;
              if (now_q.mon < 8'h12) begin
                now_d.mon = bcd_inc(now_q.mon);
              end else begin
                now_d.mon  = 8'h01;
                now_d.year = (now_q.year == 8'h99) ? 8'h00 : bcd_inc(now_q.year);
              end
            end
          end
        end
      end
    end
  end

  assign now_en = wr_en || step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      now_q <= NOW_RESET;
    else if (now_en) now_q <= now_d;
  end

  // alarm bytes sit at the odd addresses 1, 3, 5
  for (genvar gi = 0; gi < N_ALARM; gi++) begin : g_alarm
    localparam logic [3:0] ALM_ADDR = 4'(2 * gi + 1);
    logic alm_we;
    assign alm_we = wr_en && (addr == ALM_ADDR);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      alarm_q[gi] <= 8'h00;
      else if (alm_we) alarm_q[gi] <= wr_data;
    end
  end

endmodule

// File: rtl/cal_reg_port.sv
module cal_reg_port
  import cal_clock_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [3:0]              addr,
  input  logic                    wr_en,
  input  logic [7:0]              wr_data,
  input  cal_now_t                now,
  input  logic [N_ALARM-1:0][7:0] alarm,
  input  logic                    uip,
  input  logic                    busy,
  output logic                    tk_wr_en,
  output logic                    hold_q,
  output logic [7:0]              rd_data
);
  logic hold_we;

  assign hold_we  = wr_en && (addr == A_CTRL);
  assign tk_wr_en = wr_en && !busy && (addr <= A_YEAR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= 1'b0;
    else if (hold_we) hold_q <= wr_data[0];
  end

  always_comb begin
    case (addr)
      4'd0:    rd_data = now.sec;
      4'd1:    rd_data = alarm[0];
      4'd2:    rd_data = now.min;
      4'd3:    rd_data = alarm[1];
      4'd4:    rd_data = now.hour;
      4'd5:    rd_data = alarm[2];
      4'd6:    rd_data = now.dow;
      4'd7:    rd_data = now.dom;
      4'd8:    rd_data = now.mon;
      4'd9:    rd_data = now.year;
      A_STAT:  rd_data = {uip, STAT_LOW};
      A_CTRL:  rd_data = {7'd0, hold_q};
      default: rd_data = 8'h00;
    endcase
    if (busy && (addr <= A_YEAR)) rd_data = BLANK_BYTE;
  end

endmodule

// File: rtl/bcd_calendar_clock.sv
module bcd_calendar_clock
  import cal_clock_pkg::*;
#(
  parameter int TICKS_PER_SEC = 64,
  parameter int WARN_TICKS    = 8,
  parameter int BUSY_TICKS    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] reg_addr,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  logic [1:0]              rst_pipe;
  logic                    rst_sync_n;
  logic                    uip, busy, step, hold, tk_wr_en;
  cal_now_t                now_q;
  logic [N_ALARM-1:0][7:0] alarm_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  cal_sec_timer #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .WARN_TICKS    (WARN_TICKS),
    .BUSY_TICKS    (BUSY_TICKS)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .hold  (hold),
    .uip   (uip),
    .busy  (busy),
    .step  (step)
  );

  cal_time_keeper u_keeper (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .step    (step),
    .wr_en   (tk_wr_en),
    .addr    (reg_addr),
    .wr_data (reg_wdata),
    .now_q   (now_q),
    .alarm_q (alarm_q)
  );

  cal_reg_port u_port (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr     (reg_addr),
    .wr_en    (reg_we),
    .wr_data  (reg_wdata),
    .now      (now_q),
    .alarm    (alarm_q),
    .uip      (uip),
    .busy     (busy),
    .tk_wr_en (tk_wr_en),
    .hold_q   (hold),
    .rd_data  (reg_rdata)
  );

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] addr,
  input logic       we,
  input logic [7:0] rdata,
  input logic       uip,
  input logic       busy,
  input logic       step,
  input logic       hold,
  input logic [7:0] sec,
  input logic [7:0] alm0
);

  AST_BUSY_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && addr <= 4'd9) |-> (rdata == 8'hFF)); // R4

  AST_STATUS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd10) |-> (rdata == 8'h26 || rdata == 8'hA6)); // R3

  AST_STATUS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 4'd10) |-> (rdata[7] == uip)); // R3

  AST_WARN_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(uip)); // R3

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (!uip && !step)); // R9

  AST_STEP_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> busy); // R5

  AST_SEC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !(we && addr == 4'd0)) |=> $stable(sec)); // R5

  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> $stable(sec)); // R10

  AST_ALARM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == 4'd1) |=> $stable(alm0)); // R11

endmodule

bind bcd_calendar_clock cal_clock_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .addr  (reg_addr),
  .we    (reg_we),
  .rdata (reg_rdata),
  .uip   (uip),
  .busy  (busy),
  .step  (step),
  .hold  (hold),
  .sec   (now_q.sec),
  .alm0  (alarm_q[0])
);

// File: tb/bcd_calendar_clock_tb_top.sv
`timescale 1ns/10ps
module bcd_calendar_clock_tb_top;
  localparam int TPS  = 64;
  localparam int WARN = 8;
  localparam int BUSY = 4;
  localparam int WS   = TPS - WARN - BUSY;
  localparam int BS   = TPS - BUSY;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] addr;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;

  always #2 clk = ~clk;

  bcd_calendar_clock #(.TICKS_PER_SEC(TPS), .WARN_TICKS(WARN), .BUSY_TICKS(BUSY)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(addr), .reg_we(we),
    .reg_wdata(wdata), .reg_rdata(rdata));

  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 0;
  bit         held  = 0;
  int         jc    = 0;
  logic [7:0] mreg [10];

  function automatic int b2i(logic [7:0] v);
    return int'(v[7:4]) * 10 + int'(v[3:0]);
  endfunction

  function automatic logic [7:0] i2b(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic int dim(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  // integer model of one second step
  task automatic model_adv();
    int s, mi, h, dw, dm, mo, y;
    s = b2i(mreg[0]) + 1; mi = b2i(mreg[2]); h = b2i(mreg[4]);
    dw = b2i(mreg[6]); dm = b2i(mreg[7]); mo = b2i(mreg[8]); y = b2i(mreg[9]);
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h++;
        if (h == 24) begin
          h = 0; dw = (dw == 7) ? 1 : dw + 1;
          dm++;
          if (dm > dim(mo, y)) begin
            dm = 1; mo++;
            if (mo == 13) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
    mreg[0] = i2b(s); mreg[2] = i2b(mi); mreg[4] = i2b(h);
    mreg[6] = i2b(dw); mreg[7] = i2b(dm); mreg[8] = i2b(mo); mreg[9] = i2b(y);
  endtask

  function automatic logic [7:0] exp_rd(int a);
    bit bsy, flag;
    bsy  = !held && jc >= BS;
    flag = !held && jc >= WS;
    if (a <= 9)  return bsy ? 8'hFF : mreg[a];
    if (a == 10) return flag ? 8'hA6 : 8'h26;
    if (a == 11) return {7'd0, held};
    return 8'h00;
  endfunction

  task automatic chk(string tag, int a, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s addr %0d tick %0d: got %02h expected %02h", tag, a, jc, got, exp);
    end
  endtask

  // one clock; model follows the design's register semantics
  task automatic tick();
    bit         bsy_before, w;
    int         a;
    logic [7:0] d;
    bsy_before = !held && jc >= BS;
    w = we; a = int'(addr); d = wdata;
    @(posedge clk);
    if (held) jc = 0;
    else begin
      jc++;
      if (jc == TPS) begin jc = 0; model_adv(); end
    end
    if (w && a <= 9 && !bsy_before) mreg[a] = d;
    if (w && a == 11) held = d[0];
    @(negedge clk);
  endtask

  task automatic wr(int a, logic [7:0] d);
    addr = 4'(a); wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd_chk(int a, string tag);
    addr = 4'(a);
    #0.1;
    chk(tag, a, rdata, exp_rd(a));
  endtask

  task automatic chk_all(string tag);
    for (int a = 0; a < 12; a++) rd_chk(a, tag);
  endtask

  task automatic run(int n);
    repeat (n) begin
      tick();
      rd_chk(10, "R3");
      rd_chk(0, (jc >= BS) ? "R4" : "R5");
    end
  endtask

  task automatic set_time(int s, int mi, int h, int dw, int dm, int mo, int y);
    wr(11, 8'h01);
    wr(0, i2b(s)); wr(2, i2b(mi)); wr(4, i2b(h)); wr(6, i2b(dw));
    wr(7, i2b(dm)); wr(8, i2b(mo)); wr(9, i2b(y));
    wr(11, 8'h00);
  endtask

  task automatic day_end(int mo, int dm, int y, string tag);
    set_time(59, 59, 23, 3, dm, mo, y);
    run(TPS);
    rd_chk(7, tag); rd_chk(8, tag); rd_chk(9, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int s, mi, h, dw, dm, mo, y;
    void'($urandom(32'h5EED_0042));
    mreg = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
    rst_n = 1'b0; we = 1'b0; addr = 4'd0; wdata = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    tick(); tick();
    jc = 0;
    // R1: reset contents (tick count still far below the warning point)
    chk_all("R1");

    // R2: map read-back under hold, unused addresses
    wr(11, 8'h01);
    wr(0, 8'h12); wr(1, 8'h34); wr(3, 8'h45); wr(5, 8'h07);
    wr(7, 8'h15); wr(8, 8'h06); wr(9, 8'h42);
    chk_all("R2");
    wr(13, 8'h5A);
    rd_chk(13, "R2"); rd_chk(15, "R2"); rd_chk(12, "R2");

    // R9: hold freezes time and keeps the flag low
    repeat (3 * TPS) begin
      tick();
      rd_chk(10, "R9");
    end
    rd_chk(0, "R9"); rd_chk(11, "R9");
    wr(11, 8'h00);
    rd_chk(11, "R9");
    run(TPS + 5);

    // R6 and R8: full carry chain from seconds to year
    set_time(59, 59, 23, 7, 31, 12, 99);
    run(TPS);
    rd_chk(0, "R6"); rd_chk(2, "R6"); rd_chk(4, "R6"); rd_chk(6, "R6");
    rd_chk(7, "R8"); rd_chk(8, "R8"); rd_chk(9, "R8");

    // R7: month lengths and leap years
    day_end(2, 28, 24, "R7");
    day_end(2, 29, 24, "R7");
    day_end(2, 28, 23, "R7");
    day_end(2, 28, 0, "R7");
    day_end(4, 30, 51, "R7");
    day_end(1, 31, 10, "R7");
    day_end(11, 29, 10, "R7");

    // R10 and R11: writes in the busy phase are dropped, alarms kept
    set_time(10, 5, 8, 2, 14, 3, 21);
    wr(1, 8'h17);
    run(BS - 1);
    wr(0, 8'h42);
    wr(1, 8'h55);
    run(TPS - jc);
    rd_chk(0, "R10"); rd_chk(1, "R10"); rd_chk(1, "R11");

    // random dates with random alarm loads
    for (int it = 0; it < 10; it++) begin
      s  = ($urandom_range(3, 0) == 0) ? 59 : int'($urandom_range(59, 0));
      mi = ($urandom_range(2, 0) == 0) ? 59 : int'($urandom_range(59, 0));
      h  = ($urandom_range(2, 0) == 0) ? 23 : int'($urandom_range(23, 0));
      dw = int'($urandom_range(7, 1));
      mo = int'($urandom_range(12, 1));
      y  = int'($urandom_range(99, 0));
      dm = ($urandom_range(1, 0) == 0) ? dim(mo, y) : int'($urandom_range(dim(mo, y), 1));
      set_time(s, mi, h, dw, dm, mo, y);
      wr(1, 8'($urandom_range(255, 0)));
      wr(3, 8'($urandom_range(255, 0)));
      wr(5, 8'($urandom_range(255, 0)));
      run(int'($urandom_range(3, 1)) * TPS + int'($urandom_range(20, 0)));
      for (int a = 0; a < 10; a++) rd_chk(a, (a == 1 || a == 3 || a == 5) ? "R11" : "R6");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule